// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the control engine of one DMA channel that moves in one direction. It follows a chain of descriptor elements held in memory, which it reads one 32-bit word at a time through a request/response port. Each data element it finds becomes one transfer command for a downstream data mover: a byte count, a 64-bit source address and a 64-bit destination address. A link element sends the walk to a new list base address. The walker reports a two-bit channel status, pulses done and abort interrupts, and is started or resumed by a doorbell.

Whether an element may be consumed depends on a cycle bit. Each data element carries a cycle bit, and the walker compares it with its own consumer cycle state. If they differ, the element still belongs to the producer and the walker halts in front of it. A link element can invert the consumer cycle state. Software can therefore fill a ring of elements while the channel runs, then ring the doorbell again to resume from the element where the walk halted.

Both ports that carry data use valid/ready handshakes. On the memory request port, `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is sampled high. At most one read is outstanding. `mem_rsp_ready` is high only while a response is awaited. A request never overlaps a pending response. On the command port, `cmd_valid` and its payload stay unchanged until `cmd_ready` accepts them. A stalled data mover holds the walk at that element.

Top module: `llw_walker`

## Requirements
- R1: After reset the channel status is 3 (halted), no memory request and no command are pending, and no interrupt is asserted.
- R2: A doorbell starts or resumes the walk only when `eng_en` is 1, the list enable loaded by `cfg_load` is 1, `db_chan` equals the channel number and the channel is not running. A doorbell that fails any of these conditions is ignored, and so is a `cfg_load` that arrives while the channel runs.
- R3: Control word bits: bit 0 is the cycle bit, bit 1 is toggle-cycle, bit 2 marks a link element, bit 3 is the local interrupt enable and bit 4 is the remote interrupt enable. The walker reads each element's words in turn, at ascending addresses 4 bytes apart, starting with the control word.
- R4: A data element is six words: control, size, source low, source high, destination low, destination high. It produces one command with those fields. The next element is read 24 bytes further on.
- R5: If a data element's cycle bit differs from the consumer cycle state, the walk halts with status 3 and no interrupt. The list pointer stays on that element, and a later doorbell resumes there.
- R6: A link element is three words: control, next-pointer low, next-pointer high. The walk always follows it, whatever its cycle bit. When its toggle bit is set, the consumer cycle state (`cycle_state`) is inverted.
- R7: One clock after a data element's command is accepted, `irq_done_local` pulses for one cycle if bit 3 of its control word was set, and `irq_done_remote` pulses if bit 4 was set.
- R8: A data element with size 0, or a read response flagged with `mem_rsp_err`, pulses `irq_abort`, sets status 2 (fault) and halts with the pointer on that element. No command is issued for it.
- R9: A memory request stays stable until accepted, and only one request is outstanding.
- R10: A command stays stable until `cmd_ready` accepts it.
- R11: The status is 1 (running) from the doorbell until the walk halts, including while commands are handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_en | input | 1 | Global engine enable |
| cfg_load | input | 1 | Load cycle state, list enable and list pointer (ignored while running) |
| cfg_cycle | input | 1 | Initial consumer cycle state |
| cfg_list_en | input | 1 | Linked-list enable |
| cfg_list_ptr | input | 64 | List base byte address |
| db_valid | input | 1 | Doorbell strobe |
| db_chan | input | CHAN_W | Channel number written to the doorbell |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaits a response |
| mem_rsp_data | input | 32 | Read word |
| mem_rsp_err | input | 1 | Read failed |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_size | output | 32 | Transfer size in bytes |
| cmd_src | output | 64 | Source address |
| cmd_dst | output | 64 | Destination address |
| ch_status | output | 2 | 1 running, 2 fault, 3 halted |
| cycle_state | output | 1 | Consumer cycle state |
| irq_done_local | output | 1 | Local done pulse |
| irq_done_remote | output | 1 | Remote done pulse |
| irq_abort | output | 1 | Abort pulse |

## Verification
The hardest case to reach from the ports is a walk that crosses a toggling link into a second list and then halts on a stale cycle bit. The cycle state has then been inverted, and the resumed walk has to start on exactly the element that was refused. The bench builds such a ring in its memory model, lets the walker halt, rewrites the refused element with the new cycle value and rings again. It then checks the command stream and the interrupt counts. A read-error injection at a chosen word, with a resume after the error is removed, exercises the fault path in the same way. A sweep over chain lengths, with and without back-pressure, checks request counts and addresses computed arithmetically.

// File: rtl/llw_pkg.sv
package llw_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 64;
  localparam int BODY_WORDS = 5;
  localparam int LINK_WORDS = 2;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int ELEM_BYTES = (BODY_WORDS + 1) * WORD_BYTES;
  localparam int CNT_W      = $clog2(BODY_WORDS + 1);

  localparam int BIT_CYC  = 0;
  localparam int BIT_TGL  = 1;
  localparam int BIT_LNK  = 2;
  localparam int BIT_LIRQ = 3;
  localparam int BIT_RIRQ = 4;

  typedef enum logic [1:0] {
    CH_RUN   = 2'd1,
    CH_FAULT = 2'd2,
    CH_HALT  = 2'd3
  } ch_status_e;

  typedef enum logic [2:0] {
    W_HALT, W_CTL, W_LINK, W_BODY, W_CMD
  } walk_state_e;

  typedef enum logic [1:0] {
    F_IDLE, F_REQ, F_RSP
  } fetch_state_e;
endpackage

// File: rtl/llw_fetch.sv
module llw_fetch
  import llw_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [ADDR_W-1:0]                     start_addr,
  input  logic [CNT_W-1:0]                      start_count,
  output logic                                  mem_req_valid,
  input  logic                                  mem_req_ready,
  output logic [ADDR_W-1:0]                     mem_req_addr,
  input  logic                                  mem_rsp_valid,
  output logic                                  mem_rsp_ready,
  input  logic [WORD_W-1:0]                     mem_rsp_data,
  input  logic                                  mem_rsp_err,
  output logic                                  done,
  output logic                                  err,
  output logic [BODY_WORDS-1:0][WORD_W-1:0]     words
);
  fetch_state_e        st_q;
  logic [CNT_W-1:0]    cnt_q, total_q;
  logic [ADDR_W-1:0]   addr_q;

  assign mem_req_valid = (st_q == F_REQ);
  assign mem_rsp_ready = (st_q == F_RSP);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= F_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
      addr_q  <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      words   <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        F_IDLE: begin
          if (start) begin
            addr_q  <= start_addr;
            total_q <= start_count;
            cnt_q   <= '0;
            st_q    <= F_REQ;
          end
        end
        F_REQ: begin
          if (mem_req_ready) st_q <= F_RSP;
        end
        F_RSP: begin
          if (mem_rsp_valid) begin
            words[cnt_q] <= mem_rsp_data;
            if (mem_rsp_err || (cnt_q + CNT_W'(1)) == total_q) begin
              done <= 1'b1;
              err  <= mem_rsp_err;
              st_q <= F_IDLE;
            end else begin
              cnt_q  <= cnt_q + CNT_W'(1);
              addr_q <= addr_q + ADDR_W'(WORD_BYTES);
              st_q   <= F_REQ;
            end
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);

  // R3: consecutive words of one element lie 4 bytes apart
  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid) && $past(mem_rsp_valid) && !$past(done) && !done && $past(st_q) == F_RSP)
      |-> (mem_req_addr == $past(mem_req_addr) + ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/llw_cmd_slot.sv
module llw_cmd_slot
  import llw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] in_size,
  input  logic [ADDR_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_dst,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_size,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic              fire
);
  assign fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_size  <= '0;
      cmd_src   <= '0;
      cmd_dst   <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_size  <= in_size;
      cmd_src   <= in_src;
      cmd_dst   <= in_dst;
    end else if (fire) begin
      cmd_valid <= 1'b0;
    end
  end

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_size) && $stable(cmd_src) && $stable(cmd_dst)));
endmodule

// File: rtl/llw_ctrl.sv
module llw_ctrl
  import llw_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 0
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              eng_en,
  input  logic                              cfg_load,
  input  logic                              cfg_cycle,
  input  logic                              cfg_list_en,
  input  logic [ADDR_W-1:0]                 cfg_list_ptr,
  input  logic                              db_valid,
  input  logic [CHAN_W-1:0]                 db_chan,
  output logic                              fetch_start,
  output logic [ADDR_W-1:0]                 fetch_addr,
  output logic [CNT_W-1:0]                  fetch_count,
  input  logic                              fetch_done,
  input  logic                              fetch_err,
  input  logic [BODY_WORDS-1:0][WORD_W-1:0] fetch_words,
  output logic                              cmd_load,
  output logic [WORD_W-1:0]                 cmd_size,
  output logic [ADDR_W-1:0]                 cmd_src,
  output logic [ADDR_W-1:0]                 cmd_dst,
  input  logic                              cmd_fire,
  output logic [1:0]                        ch_status,
  output logic                              cycle_state,
  output logic                              irq_local,
  output logic                              irq_remote,
  output logic                              irq_abort
);
  walk_state_e       st_q;
  ch_status_e        status_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              ccs_q, lle_q, tgl_q, lirq_q, rirq_q;
  logic              db_hit;
  logic [WORD_W-1:0] w0;
  logic [ADDR_W-1:0] link_ptr, next_elem;

  assign db_hit      = db_valid && eng_en && lle_q && (db_chan == CHAN_W'(CHAN_ID));
  assign w0          = fetch_words[0];
  assign link_ptr    = {fetch_words[1], fetch_words[0]};
  assign next_elem   = ptr_q + ADDR_W'(ELEM_BYTES);
  assign ch_status   = status_q;
  assign cycle_state = ccs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= W_HALT;
      status_q    <= CH_HALT;
      ptr_q       <= '0;
      ccs_q       <= 1'b0;
      lle_q       <= 1'b0;
      tgl_q       <= 1'b0;
      lirq_q      <= 1'b0;
      rirq_q      <= 1'b0;
      fetch_start <= 1'b0;
      fetch_addr  <= '0;
      fetch_count <= '0;
      cmd_load    <= 1'b0;
      cmd_size    <= '0;
      cmd_src     <= '0;
      cmd_dst     <= '0;
      irq_local   <= 1'b0;
      irq_remote  <= 1'b0;
      irq_abort   <= 1'b0;
    end else begin
      fetch_start <= 1'b0;
      cmd_load    <= 1'b0;
      irq_local   <= 1'b0;
      irq_remote  <= 1'b0;
      irq_abort   <= 1'b0;
      case (st_q)
        W_HALT: begin
          if (cfg_load) begin
            ccs_q <= cfg_cycle;
            lle_q <= cfg_list_en;
            ptr_q <= cfg_list_ptr;
          end else if (db_hit) begin
            status_q    <= CH_RUN;
            fetch_start <= 1'b1;
            fetch_addr  <= ptr_q;
            fetch_count <= CNT_W'(1);
            st_q        <= W_CTL;
          end
        end
        W_CTL: begin
          if (fetch_done) begin
            if (fetch_err) begin
              irq_abort <= 1'b1;
              status_q  <= CH_FAULT;
              st_q      <= W_HALT;
            end else if (w0[BIT_LNK]) begin
              tgl_q       <= w0[BIT_TGL];
              fetch_start <= 1'b1;
              fetch_addr  <= ptr_q + ADDR_W'(WORD_BYTES);
              fetch_count <= CNT_W'(LINK_WORDS);
              st_q        <= W_LINK;
            end else if (w0[BIT_CYC] != ccs_q) begin
              status_q <= CH_HALT;
              st_q     <= W_HALT;
            end else begin
              lirq_q      <= w0[BIT_LIRQ];
              rirq_q      <= w0[BIT_RIRQ];
              fetch_start <= 1'b1;
              fetch_addr  <= ptr_q + ADDR_W'(WORD_BYTES);
              fetch_count <= CNT_W'(BODY_WORDS);
              st_q        <= W_BODY;
            end
          end
        end
        W_LINK: begin
          if (fetch_done) begin
            if (fetch_err) begin
              irq_abort <= 1'b1;
              status_q  <= CH_FAULT;
              st_q      <= W_HALT;
            end else begin
              ptr_q       <= link_ptr;
              if (tgl_q) ccs_q <= ~ccs_q;
              fetch_start <= 1'b1;
              fetch_addr  <= link_ptr;
              fetch_count <= CNT_W'(1);
              st_q        <= W_CTL;
            end
          end
        end
        W_BODY: begin
          if (fetch_done) begin
            if (fetch_err || w0 == '0) begin
              irq_abort <= 1'b1;
              status_q  <= CH_FAULT;
              st_q      <= W_HALT;
            end else begin
              cmd_load <= 1'b1;
              cmd_size <= w0;
              cmd_src  <= {fetch_words[2], fetch_words[1]};
              cmd_dst  <= {fetch_words[4], fetch_words[3]};
              st_q     <= W_CMD;
            end
          end
        end
        W_CMD: begin
          if (cmd_fire) begin
            irq_local   <= lirq_q;
            irq_remote  <= rirq_q;
            ptr_q       <= next_elem;
            fetch_start <= 1'b1;
            fetch_addr  <= next_elem;
            fetch_count <= CNT_W'(1);
            st_q        <= W_CTL;
          end
        end
        default: st_q <= W_HALT;
      endcase
    end
  end

  assert_db_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == CH_RUN && $past(status_q) != CH_RUN) |-> $past(db_valid && eng_en));

  assert_done_after_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_local || irq_remote) |-> $past(cmd_fire));

  assert_abort_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> $past(fetch_done));

  // R11: commands are only handed over while the channel is running
  assert_run_on_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> (status_q == CH_RUN));
endmodule

// File: rtl/llw_walker.sv
module llw_walker
  import llw_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int CHAN_ID = 0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_en,
  input  logic              cfg_load,
  input  logic              cfg_cycle,
  input  logic              cfg_list_en,
  input  logic [63:0]       cfg_list_ptr,
  input  logic              db_valid,
  input  logic [CHAN_W-1:0] db_chan,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_size,
  output logic [63:0]       cmd_src,
  output logic [63:0]       cmd_dst,
  output logic [1:0]        ch_status,
  output logic              cycle_state,
  output logic              irq_done_local,
  output logic              irq_done_remote,
  output logic              irq_abort
);
  logic                              f_start, f_done, f_err;
  logic [ADDR_W-1:0]                 f_addr;
  logic [CNT_W-1:0]                  f_count;
  logic [BODY_WORDS-1:0][WORD_W-1:0] f_words;
  logic                              c_load, c_fire;
  logic [WORD_W-1:0]                 c_size;
  logic [ADDR_W-1:0]                 c_src, c_dst;

  llw_ctrl #(.CHAN_W(CHAN_W), .CHAN_ID(CHAN_ID)) u_ctrl (
    .clk, .rst_n, .eng_en, .cfg_load, .cfg_cycle, .cfg_list_en, .cfg_list_ptr,
    .db_valid, .db_chan,
    .fetch_start(f_start), .fetch_addr(f_addr), .fetch_count(f_count),
    .fetch_done(f_done), .fetch_err(f_err), .fetch_words(f_words),
    .cmd_load(c_load), .cmd_size(c_size), .cmd_src(c_src), .cmd_dst(c_dst),
    .cmd_fire(c_fire),
    .ch_status, .cycle_state,
    .irq_local(irq_done_local), .irq_remote(irq_done_remote), .irq_abort
  );

  llw_fetch u_fetch (
    .clk, .rst_n,
    .start(f_start), .start_addr(f_addr), .start_count(f_count),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data, .mem_rsp_err,
    .done(f_done), .err(f_err), .words(f_words)
  );

  llw_cmd_slot u_slot (
    .clk, .rst_n,
    .load(c_load), .in_size(c_size), .in_src(c_src), .in_dst(c_dst),
    .cmd_valid, .cmd_ready, .cmd_size, .cmd_src, .cmd_dst,
    .fire(c_fire)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (ch_status == 2'd3 && !mem_req_valid && !cmd_valid && !irq_abort));
endmodule

// File: tb/test_llw_walker.sv
module test_llw_walker;
  localparam int CHAN_W = 3;
  localparam int CHAN   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic eng_en = 1'b0, cfg_load = 1'b0, cfg_cycle = 1'b0, cfg_list_en = 1'b0;
  logic [63:0] cfg_list_ptr = '0;
  logic db_valid = 1'b0;
  logic [CHAN_W-1:0] db_chan = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_ready;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [31:0] cmd_size;
  logic [63:0] cmd_src, cmd_dst;
  logic [1:0] ch_status;
  logic cycle_state, irq_done_local, irq_done_remote, irq_abort;

  always #10 clk = ~clk;

  llw_walker #(.CHAN_W(CHAN_W), .CHAN_ID(CHAN)) i_llw_walker (.*);

  int errors = 0, checks = 0;
  logic [31:0] mem [0:255];
  int err_idx = -1;
  bit bp_en = 0;
  logic [15:0] lf = 16'hACE1;
  int n_loc = 0, n_rem = 0, n_abt = 0, n_req = 0, cmd_n = 0, run_bad = 0, hold_bad = 0;
  logic [63:0] last_req;
  logic [31:0] rsz [0:255];
  logic [63:0] rsrc [0:255], rdst [0:255];
  int m_st = 0, m_dly = 0;
  logic [63:0] m_addr;
  bit held = 0;
  logic [159:0] snap;

  always @(negedge clk) begin
    if (rst_n) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (irq_done_local) n_loc++;
      if (irq_done_remote) n_rem++;
      if (irq_abort) n_abt++;
      if (held && cmd_valid && snap != {cmd_size, cmd_src, cmd_dst}) hold_bad++;
      cmd_ready = bp_en ? lf[0] : 1'b1;
      if (cmd_valid && cmd_ready) begin
        rsz[cmd_n[7:0]] = cmd_size; rsrc[cmd_n[7:0]] = cmd_src; rdst[cmd_n[7:0]] = cmd_dst;
        cmd_n++;
        if (ch_status != 2'd1) run_bad++;
      end
      held = cmd_valid && !cmd_ready;
      snap = {cmd_size, cmd_src, cmd_dst};
      case (m_st)
        0: begin
          mem_rsp_valid = 1'b0;
          mem_req_ready = bp_en ? lf[3] : 1'b1;
          if (mem_req_valid && mem_req_ready) begin
            m_addr = mem_req_addr; last_req = mem_req_addr; n_req++;
            m_dly = bp_en ? int'(lf[5:4]) : 0; m_st = 1;
          end
        end
        1: begin
          mem_req_ready = 1'b0;
          if (m_dly > 0) m_dly--;
          else begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = mem[m_addr[9:2]];
            mem_rsp_err = (int'(m_addr[9:2]) == err_idx);
            m_st = 2;
          end
        end
        default: begin mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; m_st = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_data(input int w, input bit cb, input bit li, input bit ri,
                          input logic [31:0] sz, input logic [63:0] s, input logic [63:0] d);
    mem[w] = {27'd0, ri, li, 1'b0, 1'b0, cb};
    mem[w+1] = sz; mem[w+2] = s[31:0]; mem[w+3] = s[63:32];
    mem[w+4] = d[31:0]; mem[w+5] = d[63:32];
  endtask

  task automatic put_link(input int w, input bit cb, input bit tg, input logic [63:0] p);
    mem[w] = {27'd0, 2'b00, 1'b1, tg, cb};
    mem[w+1] = p[31:0]; mem[w+2] = p[63:32];
  endtask

  task automatic configure(input bit cyc, input bit en, input logic [63:0] p);
    @(negedge clk); cfg_load = 1; cfg_cycle = cyc; cfg_list_en = en; cfg_list_ptr = p;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic ring(input int ch);
    @(negedge clk); db_valid = 1; db_chan = CHAN_W'(ch);
    @(negedge clk); db_valid = 0;
  endtask

  task automatic wait_halt();
    repeat (3) @(negedge clk);
    while (ch_status == 2'd1) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] ssz(int n, int i); return 32'(16 * (i + 1) + n); endfunction
  function automatic logic [63:0] ssrc(int n, int i); return {32'(32'h1000 + n), 32'(32'h2000_0000 + 64 * i)}; endfunction
  function automatic logic [63:0] sdst(int n, int i); return {32'(32'h3000 + i), 32'(32'h4000_0000 + 128 * i + n)}; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, l0, r0, a0, q0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ch_status == 2'd3, "R1 status", 64'(ch_status), 64'd3);
    check(!mem_req_valid && !cmd_valid, "R1 idle ports", {mem_req_valid, cmd_valid}, 0);
    check(n_loc + n_rem + n_abt == 0, "R1 no irq", 64'(n_loc + n_rem + n_abt), 0);

    // R2 gating: engine off, list disabled, wrong channel
    put_data(0, 1, 1, 1, 32'd8, 64'd1, 64'd2);
    put_data(6, 0, 0, 0, 32'd8, 64'd1, 64'd2);
    configure(1, 1, 64'h0);
    q0 = n_req;
    ring(CHAN); repeat (20) @(negedge clk);
    check(n_req == q0 && ch_status == 2'd3, "R2 engine off ignored", 64'(n_req - q0), 0);
    eng_en = 1;
    ring(CHAN - 1); repeat (20) @(negedge clk);
    check(n_req == q0 && ch_status == 2'd3, "R2 wrong channel ignored", 64'(n_req - q0), 0);
    configure(1, 0, 64'h0);
    ring(CHAN); repeat (20) @(negedge clk);
    check(n_req == q0 && ch_status == 2'd3, "R2 list disabled ignored", 64'(n_req - q0), 0);

    // Sweep chain length and back-pressure: R3 R4 R5 R7 R10 R11
    for (int n = 1; n <= 6; n++) begin
      for (int b = 0; b < 2; b++) begin
        int bw = 64 + 4 * n;
        bit cyc = bit'((n + b) % 2);
        logic [63:0] base = {32'(32'hA0 + n), 32'(bw * 4)};
        bp_en = bit'(b);
        for (int i = 0; i < n; i++)
          put_data(bw + 6 * i, cyc, i == n - 1, i == n - 1, ssz(n, i), ssrc(n, i), sdst(n, i));
        put_data(bw + 6 * n, ~cyc, 1, 1, 32'd4, 64'd0, 64'd0);
        configure(cyc, 1, base);
        c0 = cmd_n; l0 = n_loc; r0 = n_rem; a0 = n_abt; q0 = n_req;
        ring(CHAN); wait_halt();
        check(cmd_n - c0 == n, "R4 command count", 64'(cmd_n - c0), 64'(n));
        for (int i = 0; i < n; i++)
          check(rsz[c0 + i] == ssz(n, i) && rsrc[c0 + i] == ssrc(n, i) && rdst[c0 + i] == sdst(n, i),
                "R4 command fields", rsrc[c0 + i] ^ rdst[c0 + i], ssrc(n, i) ^ sdst(n, i));
        check(n_req - q0 == 6 * n + 1, "R3 word reads", 64'(n_req - q0), 64'(6 * n + 1));
        check(last_req == base + 64'(24 * n), "R3 halt element address", last_req, base + 64'(24 * n));
        check(n_loc - l0 == 1 && n_rem - r0 == 1, "R7 one done per chunk", 64'(n_loc - l0), 64'd1);
        check(n_abt == a0 && ch_status == 2'd3, "R5 halted quietly", 64'(ch_status), 64'd3);
      end
    end
    bp_en = 0;
    check(run_bad == 0, "R11 running during commands", 64'(run_bad), 0);
    check(hold_bad == 0, "R10 command held", 64'(hold_bad), 0);

    // R6 toggling link into second list, then R5 refill and resume
    put_data(0, 1, 0, 0, 32'd100, 64'h11, 64'h21);
    put_data(6, 1, 1, 1, 32'd101, 64'h12, 64'h22);
    put_link(12, 0, 1, 64'h0000_0007_0000_0200);
    put_data(128, 0, 1, 0, 32'd102, 64'h13, 64'h23);
    put_data(134, 1, 1, 1, 32'd999, 64'h0, 64'h0);
    configure(1, 1, 64'h0);
    c0 = cmd_n; l0 = n_loc; r0 = n_rem;
    ring(CHAN); wait_halt();
    check(cmd_n - c0 == 3, "R6 commands across link", 64'(cmd_n - c0), 3);
    check(rsz[c0 + 2] == 32'd102 && rsrc[c0 + 2] == 64'h13, "R6 element after link", rsrc[c0 + 2], 64'h13);
    check(cycle_state == 1'b0, "R6 cycle toggled", 64'(cycle_state), 0);
    check(n_loc - l0 == 2 && n_rem - r0 == 1, "R7 local/remote split", 64'(n_rem - r0), 1);
    check(last_req == 64'h0000_0007_0000_0200 + 64'd24, "R5 pointer on refused element", last_req, 64'h0000_0007_0000_0218);
    put_data(134, 0, 0, 1, 32'd103, 64'h14, 64'h24);
    put_data(140, 1, 0, 0, 32'd5, 64'h0, 64'h0);
    c0 = cmd_n; r0 = n_rem;
    ring(CHAN); wait_halt();
    check(cmd_n - c0 == 1 && rsz[c0] == 32'd103, "R5 resume at refused element", 64'(rsz[c0]), 64'd103);
    check(n_rem - r0 == 1 && ch_status == 2'd3, "R5 resume done", 64'(n_rem - r0), 1);

    // R6 link without toggle
    put_link(32, 1, 0, 64'h280);
    put_data(160, 0, 1, 0, 32'd55, 64'h31, 64'h41);
    put_data(166, 1, 0, 0, 32'd5, 64'h0, 64'h0);
    configure(0, 1, 64'h80);
    c0 = cmd_n;
    ring(CHAN); wait_halt();
    check(cmd_n - c0 == 1 && rdst[c0] == 64'h41, "R6 plain link followed", rdst[c0], 64'h41);
    check(cycle_state == 1'b0, "R6 cycle kept", 64'(cycle_state), 0);

    // R8 zero size and read error
    put_data(200, 1, 1, 1, 32'd0, 64'h5, 64'h6);
    put_data(206, 0, 0, 0, 32'd5, 64'h0, 64'h0);
    configure(1, 1, 64'(200 * 4));
    c0 = cmd_n; a0 = n_abt; l0 = n_loc;
    ring(CHAN); wait_halt();
    check(n_abt - a0 == 1 && ch_status == 2'd2, "R8 zero size abort", 64'(ch_status), 2);
    check(cmd_n == c0 && n_loc == l0, "R8 no command on abort", 64'(cmd_n - c0), 0);
    mem[201] = 32'd77; err_idx = 203;
    ring(CHAN); wait_halt();
    check(n_abt - a0 == 2 && ch_status == 2'd2 && cmd_n == c0, "R8 read error abort", 64'(n_abt - a0), 2);
    err_idx = -1;
    ring(CHAN); wait_halt();
    check(cmd_n - c0 == 1 && rsz[c0] == 32'd77 && ch_status == 2'd3, "R8 resume after fault", 64'(rsz[c0]), 77);

    // R2 doorbell and cfg_load while running are ignored
    bp_en = 1;
    for (int i = 0; i < 4; i++) put_data(64 + 6 * i, 1, i == 3, 0, ssz(9, i), ssrc(9, i), sdst(9, i));
    put_data(88, 0, 0, 0, 32'd5, 64'h0, 64'h0);
    configure(1, 1, 64'h100);
    c0 = cmd_n;
    ring(CHAN); repeat (10) @(negedge clk);
    ring(CHAN); configure(0, 1, 64'h0);
    wait_halt();
    check(cmd_n - c0 == 4 && rsz[c0 + 3] == ssz(9, 3), "R2 ignored while running", 64'(cmd_n - c0), 4);
    check(cycle_state == 1'b1, "R2 cfg ignored while running", 64'(cycle_state), 1);
    bp_en = 0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule